// File: doc/BRIEF.md
# Sprite and Playfield Collision Detector

This block watches a display pipeline one pixel at a time and records which graphical objects overlapped. For every pixel it receives the six bitplane bits and, for each of four sprite pairs, a presence flag for the even sprite and for the odd sprite. A 16-bit control word decides which bitplanes take part in playfield detection, what value each participating plane must hold, and whether each pair's odd sprite counts toward that pair.

Each valid pixel produces up to fifteen collision flags: playfield against playfield, each playfield against each sprite pair, and each sprite pair against every other pair. The flags OR into a sticky status register. A read strobe returns the accumulated value and clears the register in the same cycle. Software normally clears once per frame and reads again at the end of the frame.

Top module: `col_detect`

## Requirements
- R1: After reset the status reads 0x0000 and the control word is 0x0000. With that control word both playfields are hit on every valid pixel.
- R2: Plane k (k = 1..6, pixel bit `plane_bits[k-1]`) takes part only when control bit 5+k is 1. When it takes part it matches only if its pixel bit equals control bit k-1. A plane that does not take part always matches.
- R3: Playfield A is hit when planes 1, 3 and 5 all match. Playfield B is hit when planes 2, 4 and 6 all match.
- R4: Sprite pair p (p = 0..3) is present when `spr_even[p]` is 1, or when `spr_odd[p]` is 1 and control bit 12+p is 1. An odd sprite whose enable bit is 0 has no effect.
- R5: Status bit 0 is set when playfield A and playfield B are hit on the same pixel.
- R6: Status bit 1+p is set when playfield A and pair p are both hit. Status bit 5+p is set when playfield B and pair p are both hit.
- R7: Status bits 9 through 14 flag pair overlaps in the order (0,1), (0,2), (0,3), (1,2), (1,3), (2,3).
- R8: Status bits are sticky. Each valid pixel ORs its flags into the bits already set.
- R9: While `stat_rd` is 1, `stat_rdata` shows the accumulated value, and the register is cleared at the next clock edge. A hit on a valid pixel in that same cycle survives into the cleared register.
- R10: When `pix_valid` is 0, the pixel inputs have no effect on the status.
- R11: Status bit 15 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Loads `ctrl_wdata` into the control word |
| ctrl_wdata | input | 16 | New control word |
| pix_valid | input | 1 | The current pixel inputs are valid |
| plane_bits | input | 6 | Bitplane bits of the pixel; bit k-1 is plane k |
| spr_even | input | 4 | Even-sprite presence, one bit per pair |
| spr_odd | input | 4 | Odd-sprite presence, one bit per pair |
| stat_rd | input | 1 | Read strobe; clears the status after the cycle |
| stat_rdata | output | 16 | Accumulated collision status |

## Verification
A table of single-pixel cases changes one factor at a time: the plane enables (none, all, one), the match values against the pixel bits, and the odd-sprite enables with sprite patterns that light one pair overlap at a time. This shows that every status bit sits at its stated position and that a disabled odd sprite stays invisible. Directed sequences then check that bits from two pixels with different hits OR together, that a read clears the register, that a hit arriving with the read survives, and that pixels without the valid strobe leave the status alone. One all-hit pixel checks that bit 15 stays 0 while the other fifteen bits are set.

// File: rtl/col_pkg.sv
// Package: sizes shared by the collision detector.
// Assumes four sprite pairs and six bitplanes split evenly between two playfields.
package col_pkg;
    localparam int NUM_PLANES = 6;
    localparam int NUM_PAIRS  = 4;
    localparam int CTRL_W     = 16;
    localparam int STAT_W     = 16;
    localparam int PAIR_HITS  = NUM_PAIRS * (NUM_PAIRS - 1) / 2;
    localparam int HIT_W      = 1 + 2 * NUM_PAIRS + PAIR_HITS;
    localparam int PF_A_BASE  = 1;
    localparam int PF_B_BASE  = 1 + NUM_PAIRS;
    localparam int PAIR_BASE  = 1 + 2 * NUM_PAIRS;
    localparam int EN_BASE    = NUM_PLANES;
    localparam int ODD_BASE   = 2 * NUM_PLANES;

    // Position of the overlap flag for pairs i < j, counted from PAIR_BASE.
    function automatic int pair_slot(input int i, input int j, input int n);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) acc += n - 1 - k;
        return acc + (j - i - 1);
    endfunction
endpackage

// File: rtl/col_plane_match.sv
// Module: per-plane compare and playfield hit.
// Assumes even pixel-bit indices belong to playfield A and odd indices to playfield B.
module col_plane_match #(
    parameter int NP = 6
) (
    input  logic [NP-1:0] planes,
    input  logic [NP-1:0] match_val,
    input  logic [NP-1:0] match_en,
    output logic          pf_a_hit,
    output logic          pf_b_hit
);
    localparam int HALF = NP / 2;

    logic [NP-1:0]   plane_ok;
    logic [HALF-1:0] a_ok;
    logic [HALF-1:0] b_ok;

    genvar k;
    generate
        for (k = 0; k < NP; k++) begin : g_plane
            // A plane matches when it is excluded or equals its wanted value.
            assign plane_ok[k] = !match_en[k] || (planes[k] == match_val[k]);
        end
        for (k = 0; k < HALF; k++) begin : g_split
            assign a_ok[k] = plane_ok[2*k];
            assign b_ok[k] = plane_ok[2*k+1];
        end
    endgenerate

    // Playfield hit requires every one of its planes to match.
    always_comb begin
        pf_a_hit = &a_ok;
        pf_b_hit = &b_ok;
    end

    // R2: with no planes taking part, both playfields must report a hit.
    always_comb begin
        if (match_en == '0) begin
            assert_no_en_hits_R2 : assert (pf_a_hit && pf_b_hit);
        end
    end
endmodule

// File: rtl/col_pair_merge.sv
// Module: sprite pair presence.
// Assumes one even and one odd flag per pair; the odd one is gated by its enable.
module col_pair_merge #(
    parameter int NPAIR = 4
) (
    input  logic [NPAIR-1:0] even_in,
    input  logic [NPAIR-1:0] odd_in,
    input  logic [NPAIR-1:0] odd_en,
    output logic [NPAIR-1:0] present
);
    // A pair is present if its even sprite is, or its enabled odd sprite is.
    always_comb begin
        present = even_in | (odd_in & odd_en);
    end

    // R4: an even sprite always makes its pair present.
    always_comb begin
        assert_even_counts_R4 : assert ((present & even_in) == even_in);
    end
endmodule

// File: rtl/col_hit_map.sv
// Module: builds the per-pixel collision flag vector.
// Assumes the bit layout given by the package: bit 0, then the A and B rows, then the pair triangle.
module col_hit_map
    import col_pkg::*;
#(
    parameter int NPAIR = NUM_PAIRS
) (
    input  logic             pf_a_hit,
    input  logic             pf_b_hit,
    input  logic [NPAIR-1:0] pair_on,
    output logic [HIT_W-1:0] hits
);
    genvar i, j;
    generate
        // Playfield against playfield.
        assign hits[0] = pf_a_hit && pf_b_hit;
        for (i = 0; i < NPAIR; i++) begin : g_pf
            // Each playfield against pair i.
            assign hits[PF_A_BASE+i] = pf_a_hit && pair_on[i];
            assign hits[PF_B_BASE+i] = pf_b_hit && pair_on[i];
        end
        for (i = 0; i < NPAIR; i++) begin : g_row
            for (j = i + 1; j < NPAIR; j++) begin : g_col
                // Pair i against pair j.
                assign hits[PAIR_BASE+pair_slot(i, j, NPAIR)] = pair_on[i] && pair_on[j];
            end
        end
    endgenerate
endmodule

// File: rtl/col_status_acc.sv
// Module: sticky status register with clear-on-read.
// Assumes a read and a new hit may arrive in the same cycle; the new hit is kept.
module col_status_acc #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_valid,
    input  logic [W-1:0] hits,
    input  logic         rd,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] fresh;

    // Flags of this pixel, or none when the pixel is not valid.
    always_comb begin
        fresh = pix_valid ? hits : '0;
    end

    // Accumulate, or restart from this pixel's flags after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else if (rd) stat_q <= fresh;
        else stat_q <= stat_q | fresh;
    end

    // R8: without a read no set bit is ever lost.
    assert_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R9: a read with no valid pixel leaves an empty register.
    assert_read_clears_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !pix_valid) |=> (stat_q == '0));
    // R10: no valid pixel and no read means no change.
    assert_idle_stable_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !pix_valid) |=> $stable(stat_q));
endmodule

// File: rtl/col_detect.sv
// Module: top of the collision detector.
// Holds the control word and wires the match, pair, map and status stages.
// Assumes control writes take effect on the pixel after the write.
module col_detect
    import col_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    input  logic                  pix_valid,
    input  logic [NUM_PLANES-1:0] plane_bits,
    input  logic [NUM_PAIRS-1:0]  spr_even,
    input  logic [NUM_PAIRS-1:0]  spr_odd,
    input  logic                  stat_rd,
    output logic [STAT_W-1:0]     stat_rdata
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              pf_a_hit;
    logic              pf_b_hit;
    logic [NUM_PAIRS-1:0] pair_on;
    logic [HIT_W-1:0]  hits;
    logic [HIT_W-1:0]  stat_q;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    col_plane_match #(.NP(NUM_PLANES)) u_match (
        .planes    (plane_bits),
        .match_val (ctrl_q[NUM_PLANES-1:0]),
        .match_en  (ctrl_q[EN_BASE +: NUM_PLANES]),
        .pf_a_hit  (pf_a_hit),
        .pf_b_hit  (pf_b_hit)
    );

    col_pair_merge #(.NPAIR(NUM_PAIRS)) u_pairs (
        .even_in (spr_even),
        .odd_in  (spr_odd),
        .odd_en  (ctrl_q[ODD_BASE +: NUM_PAIRS]),
        .present (pair_on)
    );

    col_hit_map #(.NPAIR(NUM_PAIRS)) u_map (
        .pf_a_hit (pf_a_hit),
        .pf_b_hit (pf_b_hit),
        .pair_on  (pair_on),
        .hits     (hits)
    );

    col_status_acc #(.W(HIT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .hits      (hits),
        .rd        (stat_rd),
        .stat_q    (stat_q)
    );

    // Pad the status out to the port width with zeros.
    always_comb begin
        stat_rdata = '0;
        stat_rdata[HIT_W-1:0] = stat_q;
    end

    // R11: the top status bit never reads as 1.
    assert_top_bit_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[STAT_W-1] == 1'b0);
    // R1: one cycle after reset is released, status and control are both clear.
    assert_reset_clear_R1 : assert property (@(posedge clk)
        !rst_n |=> (stat_rdata == '0 && ctrl_q == '0));
endmodule

// File: tb/col_detect_test.sv
module col_detect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [5:0]  plane_bits = '0;
    logic [3:0]  spr_even = '0;
    logic [3:0]  spr_odd = '0;
    logic        stat_rd = 1'b0;
    logic [15:0] stat_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    col_detect uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .pix_valid(pix_valid), .plane_bits(plane_bits), .spr_even(spr_even),
        .spr_odd(spr_odd), .stat_rd(stat_rd), .stat_rdata(stat_rdata)
    );

    // {req tag, ctrl, planes, even, odd, expected status}
    localparam int NV = 14;
    localparam logic [49:0] VEC [0:NV-1] = '{
        {4'd5, 16'h0000, 6'h00, 4'h0, 4'h0, 16'h0001},
        {4'd6, 16'h0000, 6'h00, 4'h1, 4'h0, 16'h0023},
        {4'd2, 16'h0FC0, 6'h01, 4'h2, 4'h0, 16'h0040},
        {4'd3, 16'h0FD5, 6'h15, 4'h5, 4'h0, 16'h04AB},
        {4'd2, 16'h0082, 6'h00, 4'h8, 4'h0, 16'h0010},
        {4'd4, 16'h0FC0, 6'h3F, 4'h0, 4'hF, 16'h0000},
        {4'd4, 16'hAFC0, 6'h3F, 4'h0, 4'hF, 16'h2000},
        {4'd7, 16'h0FC0, 6'h3F, 4'hF, 4'h0, 16'h7E00},
        {4'd6, 16'h0FC0, 6'h2A, 4'hC, 4'h0, 16'h4018},
        {4'd7, 16'h1FC0, 6'h3F, 4'h2, 4'h1, 16'h0200},
        {4'd7, 16'h0FC0, 6'h3F, 4'h6, 4'h0, 16'h1000},
        {4'd7, 16'h0FC0, 6'h3F, 4'h9, 4'h0, 16'h0800},
        {4'd7, 16'h0FC0, 6'h3F, 4'h3, 4'h0, 16'h0200},
        {4'd4, 16'h2FC0, 6'h3F, 4'h4, 4'h1, 16'h0000}
    };

    function automatic string tag(input int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pixel(input logic [5:0] p, input logic [3:0] e, input logic [3:0] o, input logic v);
        @(negedge clk); pix_valid = v; plane_bits = p; spr_even = e; spr_odd = o;
        @(negedge clk); pix_valid = 1'b0; plane_bits = '0; spr_even = '0; spr_odd = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: status empty after reset.
        check("R1 reset status", stat_rdata, 16'h0000);
        // R1: reset control makes both playfields hit.
        pixel(6'h2D, 4'h0, 4'h0, 1'b1);
        check("R1 reset control", stat_rdata, 16'h0001);

        for (int i = 0; i < NV; i++) begin
            write_ctrl(VEC[i][45:30]);
            clear_status();
            pixel(VEC[i][29:24], VEC[i][23:20], VEC[i][19:16], 1'b1);
            check(tag(int'(VEC[i][49:46])), stat_rdata, VEC[i][15:0]);
        end

        // R8: two pixels with different hits accumulate.
        write_ctrl(16'h0FC0);
        clear_status();
        pixel(6'h3F, 4'h3, 4'h0, 1'b1);
        pixel(6'h3F, 4'hC, 4'h0, 1'b1);
        check("R8 accumulate", stat_rdata, 16'h4200);

        // R9: read returns value during the strobe, then clears.
        @(negedge clk); stat_rd = 1'b1;
        #1 check("R9 read value", stat_rdata, 16'h4200);
        @(negedge clk); stat_rd = 1'b0;
        check("R9 cleared", stat_rdata, 16'h0000);

        // R9: a hit coinciding with the read survives.
        pixel(6'h3F, 4'h3, 4'h0, 1'b1);
        @(negedge clk); stat_rd = 1'b1; pix_valid = 1'b1; plane_bits = 6'h3F; spr_even = 4'h9;
        #1 check("R9 old value on read", stat_rdata, 16'h0200);
        @(negedge clk); stat_rd = 1'b0; pix_valid = 1'b0; spr_even = 4'h0;
        check("R9 coincident hit kept", stat_rdata, 16'h0800);

        // R10: invalid pixels do nothing.
        clear_status();
        pixel(6'h3F, 4'hF, 4'hF, 1'b0);
        pixel(6'h00, 4'hF, 4'h0, 1'b0);
        check("R10 invalid ignored", stat_rdata, 16'h0000);

        // R11: every hit at once leaves bit 15 at zero.
        write_ctrl(16'h0000);
        clear_status();
        pixel(6'h00, 4'hF, 4'h0, 1'b1);
        check("R11 all hits", stat_rdata, 16'h7FFF);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule